// File: doc/BRIEF.md
# Oscillation Stabilization Wait Counter

After the chip leaves its low-power stop state, the main oscillator needs time to settle before the CPU may run from it. This block holds the CPU back by counting oscillator cycles. A small select register picks one of five power-of-two wait lengths. Counting starts only once the oscillator reports activity. The time between the release and the first oscillation therefore does not count toward the wait.

A read-only status word shows progress as a thermometer code, with one bit per threshold. It saturates at the selected length. When the wait ends, a one-cycle done pulse fires and a ready level stays high until the next stop entry. A release through the reset path and a release through an interrupt behave the same. A configuration check flags a requested threshold that exceeds the selected wait while the CPU runs from the internal oscillator.

Top module: `osw_wait_top`

## Requirements
- R1: After rst_ni is released, ready_o, done_o and status_o are all zero and sel_o reads 3'b101.
- R2: The select codes 3'b001, 3'b010, 3'b011, 3'b100 and 3'b101 give waits of 2^E0, 2^E1, 2^E2, 2^E3 and 2^E4 counted cycles (defaults 11, 13, 14, 15, 16). The codes 3'b000, 3'b110 and 3'b111 give the longest wait, 2^E4.
- R3: A cycle counts only when the block is out of stop, osc_run_i is high at the clock edge and the wait is not yet complete. While osc_run_i is low, no progress is made.
- R4: done_o is high for exactly the one cycle after the clock edge that completes the selected number of counted cycles. ready_o rises at that same edge and stays high until the next stop entry.
- R5: status_o bit i (bit 0 is the shortest threshold) becomes 1 at the edge that completes 2^Ei counted cycles. status_o is always a thermometer code.
- R6: Counting stops at the selected length. Status bits for thresholds longer than the selected one stay 0, however long osc_run_i remains high.
- R7: A stop_enter_i pulse clears status_o, ready_o and the count. While stopped, nothing counts, even with osc_run_i high.
- R8: A wake_rst_i pulse and a wake_irq_i pulse both end the stop state at the next edge, with identical behaviour afterwards.
- R9: cfg_err_o is combinationally high exactly when int_osc_i is 1 and the threshold index of req_thr_i is above that of sel_o. Both use the R2 code-to-index mapping: 001→0, 010→1, 011→2, 100→3, and any other code→4.
- R10: When sel_we_i is high at a clock edge, sel_wdata_i is loaded, and sel_o shows it from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_we_i | input | 1 | Write strobe for the wait-length select |
| sel_wdata_i | input | 3 | Select code to write |
| sel_o | output | 3 | Select register readback |
| stop_enter_i | input | 1 | Pulse: entering stop state |
| wake_rst_i | input | 1 | Pulse: stop released by the reset path |
| wake_irq_i | input | 1 | Pulse: stop released by an interrupt |
| osc_run_i | input | 1 | Oscillator is running |
| int_osc_i | input | 1 | CPU is clocked from the internal oscillator |
| req_thr_i | input | 3 | Requested status threshold code |
| status_o | output | 5 | Thermometer progress status |
| done_o | output | 1 | One-cycle wait-complete pulse |
| ready_o | output | 1 | Wait complete, held until next stop |
| cfg_err_o | output | 1 | Requested threshold exceeds selected wait |

## Verification
A wrong count shows at the ports in two ways. status_o bits flip a cycle early or late, and done_o moves away from the exact edge where the bench's model reaches the selected length. The bench samples every cycle of each wait, so such an error is caught in the cycle it occurs. A count that keeps running past the selected length, or that counts while osc_run_i is low or during stop, shows up as a status bit that should stay clear, or as ready_o rising early. A stale stop flag shows as a wait that never completes, which the per-cycle comparison of ready_o exposes once the expected length passes.

// File: rtl/osw_pkg.sv
package osw_pkg;
   localparam int unsigned NUM_THR = 5;
   localparam int unsigned EXP_W   = 5;
   localparam int unsigned IDX_W   = 3;

   typedef logic [2:0]       sel_code_t;
   typedef logic [IDX_W-1:0] thr_idx_t;

   localparam sel_code_t SEL_RESET = 3'b101;

   // reserved codes fall back to the longest wait
   function automatic thr_idx_t code_to_idx(input sel_code_t code);
      thr_idx_t idx;
      case (code)
         3'b001:  idx = 3'd0;
         3'b010:  idx = 3'd1;
         3'b011:  idx = 3'd2;
         3'b100:  idx = 3'd3;
         default: idx = 3'd4;
      endcase
      return idx;
   endfunction
endpackage

// File: rtl/osw_sel_reg.sv
module osw_sel_reg
   import osw_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter logic [NUM_THR*EXP_W-1:0] EXPS = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             we_i,
   input  sel_code_t        wdata_i,
   output sel_code_t        sel_o,
   output thr_idx_t         idx_o,
   output logic [CNT_W-1:0] term_o
);
   sel_code_t        sel_q;
   logic [CNT_W-1:0] term_tab [NUM_THR];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   sel_q <= SEL_RESET;
      else if (we_i) sel_q <= wdata_i;
   end

   for (genvar g = 0; g < NUM_THR; g++) begin : g_term
      localparam logic [CNT_W:0] FULL =
         ((CNT_W+1)'(1) << EXPS[g*EXP_W +: EXP_W]) - (CNT_W+1)'(1);
      assign term_tab[g] = FULL[CNT_W-1:0];
   end

   assign idx_o  = code_to_idx(sel_q);
   assign term_o = term_tab[idx_o];
   assign sel_o  = sel_q;

   always @(posedge clk_i) begin
      if (rst_ni) AST_SEL_WRITE: assert (!($past(we_i) && $past(rst_ni)) || sel_q == $past(wdata_i)); // R10
   end
endmodule

// File: rtl/osw_counter.sv
module osw_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             stop_enter_i,
   input  logic             wake_i,
   input  logic             osc_run_i,
   input  logic [CNT_W-1:0] term_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             counting_o,
   output logic             done_o,
   output logic             ready_o
);
   logic             in_stop_q, ready_q, done_q;
   logic [CNT_W-1:0] cnt_q;
   logic             finish;

   assign counting_o = !in_stop_q && osc_run_i && !ready_q;
   assign finish     = counting_o && (cnt_q >= term_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         in_stop_q <= 1'b0;
         ready_q   <= 1'b0;
         done_q    <= 1'b0;
         cnt_q     <= '0;
      end else if (stop_enter_i) begin
         in_stop_q <= 1'b1;
         ready_q   <= 1'b0;
         done_q    <= 1'b0;
         cnt_q     <= '0;
      end else begin
         if (wake_i) in_stop_q <= 1'b0;
         done_q <= finish;
         if (finish)          ready_q <= 1'b1;
         else if (counting_o) cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign cnt_o   = cnt_q;
   assign done_o  = done_q;
   assign ready_o = ready_q;

   AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |=> !done_q); // R4
   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!osc_run_i && !stop_enter_i) |=> $stable(cnt_q)); // R3
   AST_STOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_stop_q |-> (cnt_q == '0 && !ready_q)); // R7
   AST_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_q && !stop_enter_i) |=> ($stable(cnt_q) && ready_q)); // R6
endmodule

// File: rtl/osw_status.sv
module osw_status
   import osw_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter logic [NUM_THR*EXP_W-1:0] EXPS = '0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               clear_i,
   input  logic               counting_i,
   input  logic [CNT_W-1:0]   cnt_i,
   output logic [NUM_THR-1:0] status_o
);
   logic [NUM_THR-1:0] stat_q;

   for (genvar g = 0; g < NUM_THR; g++) begin : g_bit
      localparam logic [CNT_W:0] FULL =
         ((CNT_W+1)'(1) << EXPS[g*EXP_W +: EXP_W]) - (CNT_W+1)'(1);
      localparam logic [CNT_W-1:0] HIT = FULL[CNT_W-1:0];
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                          stat_q[g] <= 1'b0;
         else if (clear_i)                     stat_q[g] <= 1'b0;
         else if (counting_i && cnt_i == HIT)  stat_q[g] <= 1'b1;
      end
   end

   assign status_o = stat_q;

   AST_STATUS_THERMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((stat_q + 1'b1) & stat_q) == '0); // R5
endmodule

// File: rtl/osw_cfg_check.sv
module osw_cfg_check
   import osw_pkg::*;
#(
   parameter bit CHECK_EN = 1'b1
) (
   input  logic      int_osc_i,
   input  sel_code_t req_i,
   input  thr_idx_t  sel_idx_i,
   output logic      err_o
);
   if (CHECK_EN) begin : g_on
      assign err_o = int_osc_i && (code_to_idx(req_i) > sel_idx_i);
   end else begin : g_off
      logic unused;
      assign unused = int_osc_i ^ (^req_i) ^ (^sel_idx_i);
      assign err_o  = 1'b0;
   end
endmodule

// File: rtl/osw_wait_top.sv
module osw_wait_top
   import osw_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned E0 = 11,
   parameter int unsigned E1 = 13,
   parameter int unsigned E2 = 14,
   parameter int unsigned E3 = 15,
   parameter int unsigned E4 = 16,
   parameter bit CFG_CHECK_EN = 1'b1
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       sel_we_i,
   input  logic [2:0] sel_wdata_i,
   output logic [2:0] sel_o,
   input  logic       stop_enter_i,
   input  logic       wake_rst_i,
   input  logic       wake_irq_i,
   input  logic       osc_run_i,
   input  logic       int_osc_i,
   input  logic [2:0] req_thr_i,
   output logic [4:0] status_o,
   output logic       done_o,
   output logic       ready_o,
   output logic       cfg_err_o
);
   localparam logic [NUM_THR*EXP_W-1:0] EXPS =
      {EXP_W'(E4), EXP_W'(E3), EXP_W'(E2), EXP_W'(E1), EXP_W'(E0)};

   if (!(E0 >= 1 && E0 < E1 && E1 < E2 && E2 < E3 && E3 < E4)) begin : g_bad_order
      $error("wait exponents must be strictly increasing and nonzero");
   end
   if (E4 > CNT_W) begin : g_bad_width
      $error("longest wait exceeds counter width");
   end

   thr_idx_t         sel_idx;
   logic [CNT_W-1:0] term, cnt;
   logic             counting;

   osw_sel_reg #(.CNT_W(CNT_W), .EXPS(EXPS)) u_sel (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(sel_we_i), .wdata_i(sel_wdata_i),
      .sel_o(sel_o), .idx_o(sel_idx), .term_o(term));

   osw_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .stop_enter_i(stop_enter_i),
      .wake_i(wake_rst_i | wake_irq_i), .osc_run_i(osc_run_i), .term_i(term),
      .cnt_o(cnt), .counting_o(counting), .done_o(done_o), .ready_o(ready_o));

   osw_status #(.CNT_W(CNT_W), .EXPS(EXPS)) u_stat (
      .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(stop_enter_i),
      .counting_i(counting), .cnt_i(cnt), .status_o(status_o));

   osw_cfg_check #(.CHECK_EN(CFG_CHECK_EN)) u_cfg (
      .int_osc_i(int_osc_i), .req_i(req_thr_i), .sel_idx_i(sel_idx),
      .err_o(cfg_err_o));

   AST_READY_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> ready_o); // R4
   AST_CLEAR_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_enter_i |=> (status_o == '0 && !ready_o && !done_o)); // R7
endmodule

// File: tb/tb_osw_wait_top.sv
`timescale 1ns/1ps
module tb_osw_wait_top;
   localparam int unsigned X0 = 3, X1 = 5, X2 = 6, X3 = 7, X4 = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_we = 1'b0;
   logic [2:0] sel_wdata = '0;
   logic [2:0] sel_q;
   logic       stop_enter = 1'b0, wake_rst = 1'b0, wake_irq = 1'b0;
   logic       osc_run = 1'b0, int_osc = 1'b0;
   logic [2:0] req_thr = '0;
   logic [4:0] status;
   logic       done, ready, cfg_err;

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   osw_wait_top #(.E0(X0), .E1(X1), .E2(X2), .E3(X3), .E4(X4)) dut (
      .clk_i(clk), .rst_ni(rst_n), .sel_we_i(sel_we), .sel_wdata_i(sel_wdata),
      .sel_o(sel_q), .stop_enter_i(stop_enter), .wake_rst_i(wake_rst),
      .wake_irq_i(wake_irq), .osc_run_i(osc_run), .int_osc_i(int_osc),
      .req_thr_i(req_thr), .status_o(status), .done_o(done), .ready_o(ready),
      .cfg_err_o(cfg_err));

   function automatic int m_idx(input logic [2:0] c);
      if (c >= 3'd1 && c <= 3'd4) return int'(c) - 1;
      return 4;
   endfunction

   function automatic int m_len(input int idx);
      case (idx)
         0: return 1 << X0;
         1: return 1 << X1;
         2: return 1 << X2;
         3: return 1 << X3;
         default: return 1 << X4;
      endcase
   endfunction

   function automatic int m_therm(input int n, input int idx);
      int v = 0;
      for (int i = 0; i < 5; i++)
         if (i <= idx && n >= m_len(i)) v |= (1 << i);
      return v;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run_wait(input logic [2:0] code, input bit by_irq,
                           input int gap, input bit pauses);
      int len, idx, n, tail;
      bit made;
      idx = m_idx(code);
      len = m_len(idx);
      @(negedge clk);
      sel_we = 1'b1; sel_wdata = code; stop_enter = 1'b1; osc_run = 1'b1;
      @(negedge clk);
      sel_we = 1'b0; stop_enter = 1'b0;
      chk("R10 sel readback", int'(sel_q), int'(code));
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R7 status held in stop", int'(status), 0);
         chk("R7 ready held in stop", int'(ready), 0);
      end
      osc_run = 1'b0;
      @(negedge clk);
      if (by_irq) wake_irq = 1'b1; else wake_rst = 1'b1;
      @(negedge clk);
      wake_irq = 1'b0; wake_rst = 1'b0;
      for (int k = 0; k < gap; k++) begin
         @(negedge clk);
         chk("R3 no progress before osc", int'(status), 0);
         chk(by_irq ? "R8 irq wake not ready" : "R8 rst wake not ready", int'(ready), 0);
      end
      n = 0; tail = 0;
      while (tail < 4) begin
         osc_run = (pauses && n > 0 && ($urandom % 4 == 0)) ? 1'b0 : 1'b1;
         @(posedge clk);
         made = 1'b0;
         if (osc_run && n < len) begin
            n++;
            made = (n == len);
         end
         @(negedge clk);
         if (n >= len) tail++;
         chk("R5 status progress", int'(status), m_therm(n, idx));
         chk("R4 done pulse", int'(done), int'(made));
         chk(by_irq ? "R8 ready irq" : "R8 ready rst", int'(ready), int'(n >= len));
      end
      chk("R6 no longer thresholds", int'(status) & ~m_therm(1 << 30, idx), 0);
      chk("R2 wait length reached", int'(ready), 1);
      osc_run = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL R4 watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk("R1 ready", int'(ready), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 status", int'(status), 0);
      chk("R1 sel reset", int'(sel_q), 5);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 sel after release", int'(sel_q), 5);
      chk("R1 status after release", int'(status), 0);

      // directed: each valid code and each reserved code (R2)
      run_wait(3'b001, 1'b0, 3, 1'b0);
      run_wait(3'b010, 1'b1, 1, 1'b0);
      run_wait(3'b011, 1'b0, 7, 1'b1);
      run_wait(3'b100, 1'b1, 2, 1'b0);
      run_wait(3'b101, 1'b0, 5, 1'b1);
      run_wait(3'b000, 1'b1, 4, 1'b0);
      run_wait(3'b110, 1'b0, 1, 1'b0);
      run_wait(3'b111, 1'b1, 2, 1'b1);

      // random waits
      for (int r = 0; r < 12; r++)
         run_wait(3'($urandom % 8), 1'($urandom % 2), 1 + int'($urandom % 20),
                  1'($urandom % 2));

      // configuration check, R9
      for (int r = 0; r < 60; r++) begin
         @(negedge clk);
         sel_we = 1'b1; sel_wdata = 3'($urandom % 8);
         @(negedge clk);
         sel_we = 1'b0;
         int_osc = 1'($urandom % 2);
         req_thr = 3'($urandom % 8);
         #1;
         chk("R9 cfg error", int'(cfg_err),
             int'(int_osc && (m_idx(req_thr) > m_idx(sel_q))));
         chk("R10 sel write", int'(sel_q), int'(sel_wdata));
      end
      int_osc = 1'b1; req_thr = 3'b110;
      @(negedge clk); sel_we = 1'b1; sel_wdata = 3'b001;
      @(negedge clk); sel_we = 1'b0; #1;
      chk("R9 reserved request above shortest", int'(cfg_err), 1);
      int_osc = 1'b0; #1;
      chk("R9 external osc no error", int'(cfg_err), 0);

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule